// File: doc/BRIEF.md
# Multi-Channel Interprocessor Mailbox

This block lets several processors on one chip pass short fixed-length messages to each other and raise interrupts on each other. It sits on a simple word-addressed register bus that has an address, write data, a write enable and registered read data. It drives one interrupt line per processor vector. The address space holds a number of independent one-way channels, each in its own 64-byte window, plus a global lock register that must be opened with a key before any channel register accepts a write.

A sender first claims an idle channel by writing its own one-hot vector into the channel's owner register and reading it back. It then chooses the destination vector, unmasks it, optionally selects automatic acknowledge, fills the eight-word message buffer, and triggers the send by writing its owner vector to the send register. The channel leaves idle and flags the destination as pending. The unmasked pending bit reaches the interrupt output. In automatic-acknowledge mode the channel turns itself to the acknowledged state on the next cycle, so the sender can reuse it without help from the receiver. The receiver reads the message, then clears the pending bit through the destination-clear register.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset every channel reads idle (mode word 0x10), owner 0, destination 0 and mask all ones. The lock register at 0xA00 reads 1 and `irq_o` is all zeros.
- R2: Writing 0x1ACCE551 to 0xA00 opens the lock, and that register then reads 0. Writing any other value to 0xA00 closes it again, and it then reads 1.
- R3: While the lock is closed, writes to any channel register or message word are ignored. The registers keep the values they held before.
- R4: A write to the owner register (offset 0x00) of a channel that is idle or acknowledged stores the value. After it the channel reads idle, with mode bit 4 set and bit 7 clear.
- R5: A write to the owner register of a busy channel (sent, not yet acknowledged) is ignored.
- R6: A write to the send register (offset 0x1C) of an idle channel starts a transfer only if the value equals the nonzero owner vector. The channel then reads busy, with bits 4 and 7 both clear, and its destination vector (offset 0x04) is ORed into the pending vector. Any other send value is ignored.
- R7: `irq_o` is registered. A vector bit rises one cycle after its pending bit is set while unmasked, or one cycle after it is unmasked while pending, and falls one cycle after it is cleared. `irq_o` is the OR over all channels of pending AND NOT mask, where the mask sits at offset 0x14 and a 1 masks.
- R8: Mode bit 0 (offset 0x10) selects automatic acknowledge. With it set, a busy channel becomes acknowledged (bit 7 = 1) one cycle after the send. Without it, the channel stays busy.
- R9: Writing a vector to the destination-clear register (0x08) clears those pending bits. The destination-status register (0x0C) reads pending AND NOT mask.
- R10: Eight 32-bit message words at offsets 0x20 to 0x3C are written and read back per channel, with no interference between channels.
- R11: Any write to the interrupt-clear register (0x18) of an acknowledged channel returns it to idle. The owner is kept.
- R12: Read data appears one cycle after the address. Reads of unmapped or non-word-aligned addresses return 0, and write-only offsets (0x08, 0x18, 0x1C) read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | AW (12) | Byte address of the access |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write strobe for this cycle |
| rdata_o | output | 32 | Registered read data for the previous cycle's address |
| irq_o | output | NUM_VEC (32) | One interrupt line per processor vector |

## Verification
A write presented before a rising edge changes channel state at that edge. A read presented at the next edge returns that state after the edge, so each register check follows its stimulus by exactly one read cycle. Two results lag one cycle more. An automatic acknowledge becomes visible only on the second read after the send: the first read still shows busy, and the bench checks both values. The interrupt output is checked at the first and at the second falling edge after the causing write, so that it is low and then high, or high and then low. The bench samples everything at falling edges and drives inputs there.

// File: rtl/ipc_mbox_pkg.sv
package ipc_mbox_pkg;
  typedef enum logic [1:0] {
    CH_IDLE  = 2'd0,
    CH_BUSY  = 2'd1,
    CH_ACKED = 2'd2
  } ch_state_e;

  // word offsets inside the control half of a channel window
  localparam logic [2:0] OFF_SRC   = 3'd0;
  localparam logic [2:0] OFF_DST   = 3'd1;
  localparam logic [2:0] OFF_DCLR  = 3'd2;
  localparam logic [2:0] OFF_DSTAT = 3'd3;
  localparam logic [2:0] OFF_MODE  = 3'd4;
  localparam logic [2:0] OFF_MASK  = 3'd5;
  localparam logic [2:0] OFF_ICLR  = 3'd6;
  localparam logic [2:0] OFF_SEND  = 3'd7;

  localparam int MODE_AUTO_BIT = 0;
  localparam int MODE_IDLE_BIT = 4;
  localparam int MODE_ACK_BIT  = 7;

  localparam logic [31:0] UNLOCK_KEY = 32'h1ACC_E551;
endpackage

// File: rtl/mbox_lock.sv
module mbox_lock
  import ipc_mbox_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [31:0] wr_val,
  output logic        locked_o
);
  logic locked_q;

  always_ff @(posedge clk) begin
    if (rst)        locked_q <= 1'b1;
    else if (wr_en) locked_q <= (wr_val != UNLOCK_KEY);
  end

  assign locked_o = locked_q;

  assert_key_unlocks_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_val == UNLOCK_KEY) |=> !locked_o);
endmodule

// File: rtl/mbox_msg_ram.sv
module mbox_msg_ram #(
  parameter int DEPTH = 256,
  parameter int DW    = 32,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/mbox_chan.sv
module mbox_chan
  import ipc_mbox_pkg::*;
#(
  parameter int NUM_VEC = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [2:0]         wr_off,
  input  logic [NUM_VEC-1:0] wr_vec,
  input  logic               wr_mode,
  output logic [NUM_VEC-1:0] src_o,
  output logic [NUM_VEC-1:0] dst_o,
  output logic [NUM_VEC-1:0] mask_o,
  output logic [NUM_VEC-1:0] pend_o,
  output logic               auto_o,
  output logic               idle_o,
  output logic               ack_o
);
  ch_state_e          state_q;
  logic [NUM_VEC-1:0] src_q, dst_q, mask_q, pend_q;
  logic               auto_q;
  logic               send_ok;

  assign send_ok = wr_en && wr_off == OFF_SEND && state_q == CH_IDLE &&
                   src_q != '0 && wr_vec == src_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= CH_IDLE;
      src_q   <= '0;
      dst_q   <= '0;
      mask_q  <= '1;
      pend_q  <= '0;
      auto_q  <= 1'b0;
    end else begin
      if (state_q == CH_BUSY && auto_q) state_q <= CH_ACKED;
      if (wr_en) begin
        case (wr_off)
          OFF_SRC:  if (state_q != CH_BUSY) begin
                      src_q   <= wr_vec;
                      state_q <= CH_IDLE;
                    end
          OFF_DST:  dst_q  <= wr_vec;
          OFF_DCLR: pend_q <= pend_q & ~wr_vec;
          OFF_MODE: auto_q <= wr_mode;
          OFF_MASK: mask_q <= wr_vec;
          OFF_ICLR: if (state_q == CH_ACKED) state_q <= CH_IDLE;
          OFF_SEND: if (send_ok) begin
                      state_q <= CH_BUSY;
                      pend_q  <= pend_q | dst_q;
                    end
          default:  ;
        endcase
      end
    end
  end

  assign src_o  = src_q;
  assign dst_o  = dst_q;
  assign mask_o = mask_q;
  assign pend_o = pend_q;
  assign auto_o = auto_q;
  assign idle_o = (state_q == CH_IDLE);
  assign ack_o  = (state_q == CH_ACKED);

  assert_claim_ok_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_off == OFF_SRC && state_q != CH_BUSY) |=>
      (state_q == CH_IDLE && src_q == $past(wr_vec)));

  assert_busy_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_off == OFF_SRC && state_q == CH_BUSY) |=> $stable(src_q));

  assert_send_pend_R6: assert property (@(posedge clk) disable iff (rst)
    send_ok |=> ((pend_q & $past(dst_q)) == $past(dst_q)) && state_q != CH_IDLE);

  assert_auto_ack_R8: assert property (@(posedge clk) disable iff (rst)
    (state_q == CH_BUSY && auto_q) |=> (state_q == CH_ACKED));
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import ipc_mbox_pkg::*;
#(
  parameter int          NUM_CH    = 32,
  parameter int          NUM_VEC   = 32,
  parameter int          MSG_WORDS = 8,
  parameter int          AW        = 12,
  parameter logic [11:0] LOCK_ADDR = 12'hA00
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [AW-1:0]      addr_i,
  input  logic [31:0]        wdata_i,
  input  logic               we_i,
  output logic [31:0]        rdata_o,
  output logic [NUM_VEC-1:0] irq_o
);
  localparam int CH_BITS   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int WORD_BITS = (MSG_WORDS > 1) ? $clog2(MSG_WORDS) : 1;
  localparam int HALF_BITS = ((WORD_BITS > 3) ? WORD_BITS : 3) + 2;
  localparam int WIN_BITS  = HALF_BITS + 1;
  localparam int MEM_DEPTH = (2 ** CH_BITS) * (2 ** WORD_BITS);
  localparam int MEM_IW    = CH_BITS + WORD_BITS;

  // address decode
  logic [AW-1:0]        win_num;
  logic [CH_BITS-1:0]   ch_idx;
  logic [2:0]           reg_off;
  logic [WORD_BITS-1:0] word_idx;
  logic                 aligned, in_chan, is_data, lock_hit, locked;

  assign win_num  = addr_i >> WIN_BITS;
  assign ch_idx   = win_num[CH_BITS-1:0];
  assign reg_off  = addr_i[4:2];
  assign word_idx = addr_i[2 +: WORD_BITS];
  assign aligned  = (addr_i[1:0] == 2'b00);
  assign in_chan  = aligned && (win_num < AW'(NUM_CH));
  assign is_data  = addr_i[HALF_BITS];
  assign lock_hit = (addr_i == AW'(LOCK_ADDR));

  mbox_lock u_lock (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (we_i && lock_hit),
    .wr_val   (wdata_i),
    .locked_o (locked)
  );

  // channels
  logic [NUM_VEC-1:0] src_a  [NUM_CH];
  logic [NUM_VEC-1:0] dst_a  [NUM_CH];
  logic [NUM_VEC-1:0] mask_a [NUM_CH];
  logic [NUM_VEC-1:0] pend_a [NUM_CH];
  logic [NUM_CH-1:0]  auto_a, idle_a, ack_a;
  logic               ctrl_we;

  assign ctrl_we = we_i && !locked && in_chan && !is_data;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    mbox_chan #(.NUM_VEC(NUM_VEC)) u_ch (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (ctrl_we && ch_idx == CH_BITS'(c)),
      .wr_off  (reg_off),
      .wr_vec  (wdata_i[NUM_VEC-1:0]),
      .wr_mode (wdata_i[0]),
      .src_o   (src_a[c]),
      .dst_o   (dst_a[c]),
      .mask_o  (mask_a[c]),
      .pend_o  (pend_a[c]),
      .auto_o  (auto_a[c]),
      .idle_o  (idle_a[c]),
      .ack_o   (ack_a[c])
    );
  end

  // message buffer
  logic [31:0] mem_rd;

  mbox_msg_ram #(.DEPTH(MEM_DEPTH), .DW(32)) u_ram (
    .clk   (clk),
    .we    (we_i && !locked && in_chan && is_data),
    .waddr (MEM_IW'({ch_idx, word_idx})),
    .wdata (wdata_i),
    .raddr (MEM_IW'({ch_idx, word_idx})),
    .rdata (mem_rd)
  );

  // register read path
  logic [31:0] rd_next, rd_q;
  logic        sel_data_q;

  always_comb begin
    rd_next = '0;
    if (aligned && lock_hit) begin
      rd_next = {31'd0, locked};
    end else if (in_chan && !is_data) begin
      case (reg_off)
        OFF_SRC:   rd_next = 32'(src_a[ch_idx]);
        OFF_DST:   rd_next = 32'(dst_a[ch_idx]);
        OFF_DSTAT: rd_next = 32'(pend_a[ch_idx] & ~mask_a[ch_idx]);
        OFF_MASK:  rd_next = 32'(mask_a[ch_idx]);
        OFF_MODE: begin
          rd_next[MODE_AUTO_BIT] = auto_a[ch_idx];
          rd_next[MODE_IDLE_BIT] = idle_a[ch_idx];
          rd_next[MODE_ACK_BIT]  = ack_a[ch_idx];
        end
        default:   rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q       <= '0;
      sel_data_q <= 1'b0;
    end else begin
      rd_q       <= rd_next;
      sel_data_q <= in_chan && is_data;
    end
  end

  assign rdata_o = sel_data_q ? mem_rd : rd_q;

  // interrupt output
  logic [NUM_VEC-1:0] irq_next, irq_q;

  always_comb begin
    irq_next = '0;
    for (int c = 0; c < NUM_CH; c++) irq_next |= pend_a[c] & ~mask_a[c];
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= '0;
    else     irq_q <= irq_next;
  end

  assign irq_o = irq_q;

  assert_locked_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    (we_i && locked && in_chan && !is_data && reg_off == OFF_MASK) |=>
      $stable(mask_a[$past(ch_idx)]));
endmodule

// File: tb/test_ipc_mailbox.sv
`timescale 1ns/1ps
module test_ipc_mailbox;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0;
  logic [31:0] rdata;
  logic [31:0] irq;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ipc_mailbox i_ipc_mailbox (
    .clk(clk), .rst(rst), .addr_i(addr), .wdata_i(wdata),
    .we_i(we), .rdata_o(rdata), .irq_o(irq)
  );

  localparam logic [31:0] KEY = 32'h1ACC_E551;

  function automatic logic [11:0] ra(input int ch, input int off);
    return 12'(ch * 64 + off);
  endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk); @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    addr = a; we = 1'b0;
    @(posedge clk); @(negedge clk);
    v = rdata;
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle1();
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    logic [31:0] v, own, dst, exp_mode;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1", "irq after reset", irq, 32'h0);
    rd(12'hA00, v);          chk("R1", "lock reads closed", v, 32'h1);
    rd(ra(5, 'h10), v);      chk("R1", "mode idle", v, 32'h10);
    rd(ra(5, 'h14), v);      chk("R1", "mask all ones", v, 32'hFFFF_FFFF);
    rd(ra(5, 'h00), v);      chk("R1", "owner clear", v, 32'h0);
    rd(ra(31, 'h04), v);     chk("R1", "dest clear", v, 32'h0);

    // R3 locked writes are ignored
    wr(ra(1, 'h14), 32'h0);  rd(ra(1, 'h14), v);
    chk("R3", "mask write while locked", v, 32'hFFFF_FFFF);
    wr(ra(1, 'h00), 32'h4);  rd(ra(1, 'h00), v);
    chk("R3", "owner write while locked", v, 32'h0);

    // R2 unlock
    wr(12'hA00, KEY);        rd(12'hA00, v);
    chk("R2", "lock open after key", v, 32'h0);

    // R12 unmapped and misaligned reads
    rd(12'h900, v);          chk("R12", "unmapped read", v, 32'h0);
    rd(ra(2, 'h15), v);      chk("R12", "misaligned read", v, 32'h0);

    // sweep every channel
    for (int ch = 0; ch < 32; ch++) begin
      own = 32'h1 << ch;
      dst = 32'h1 << ((ch * 7 + 3) % 32);
      wr(ra(ch, 'h00), own);
      rd(ra(ch, 'h00), v);   chk("R4", "claim readback", v, own);
      rd(ra(ch, 'h10), v);   chk("R4", "claimed channel idle", v, 32'h10);
      wr(ra(ch, 'h14), ~dst);
      wr(ra(ch, 'h04), dst);
      wr(ra(ch, 'h10), (ch % 2 == 0) ? 32'h1 : 32'h0);
      for (int i = 0; i < 8; i++)
        wr(ra(ch, 'h20 + 4 * i), 32'hA500_0000 ^ (ch * 32'h0101_0101) ^ (i * 32'h11));
      wr(ra(ch, 'h1C), ~own);
      rd(ra(ch, 'h10), v);
      chk("R6", "wrong send value ignored", v, (ch % 2 == 0) ? 32'h11 : 32'h10);
      wr(ra(ch, 'h1C), own);
      chk("R7", "irq not yet up", irq, 32'h0);
      rd(ra(ch, 'h10), v);   chk("R6", "busy after send", v, (ch % 2 == 0) ? 32'h1 : 32'h0);
      chk("R7", "irq raised", irq, dst);
      exp_mode = (ch % 2 == 0) ? 32'h81 : 32'h00;
      rd(ra(ch, 'h10), v);   chk("R8", "ack state after send", v, exp_mode);
      rd(ra(ch, 'h0C), v);   chk("R9", "status pending", v, dst);
      wr(ra(ch, 'h00), 32'h8000_0000 >> ch | 32'h1);
      rd(ra(ch, 'h00), v);
      chk((ch % 2 == 0) ? "R4" : "R5", "owner after busy/ack write", v,
          (ch % 2 == 0) ? (32'h8000_0000 >> ch | 32'h1) : own);
      for (int i = 0; i < 8; i++) begin
        rd(ra(ch, 'h20 + 4 * i), v);
        chk("R10", "message word", v, 32'hA500_0000 ^ (ch * 32'h0101_0101) ^ (i * 32'h11));
      end
      rd(ra(ch, 'h1C), v);   chk("R12", "send reads zero", v, 32'h0);
      wr(ra(ch, 'h08), dst);
      chk("R7", "irq still up one cycle", irq, dst);
      rd(ra(ch, 'h0C), v);   chk("R9", "status cleared", v, 32'h0);
      chk("R7", "irq dropped", irq, 32'h0);
      if (ch % 2 == 0) begin
        wr(ra(ch, 'h00), own);          // re-claim from acked
        rd(ra(ch, 'h10), v);   chk("R4", "re-claim returns idle", v, 32'h11);
      end
    end

    // R11 interrupt clear from acked, and R7 masking on channel 0
    own = 32'h1; dst = 32'h4;
    wr(ra(0, 'h00), own);
    wr(ra(0, 'h14), 32'hFFFF_FFFF);
    wr(ra(0, 'h04), dst);
    wr(ra(0, 'h1C), own);
    idle1();
    chk("R7", "masked pending gives no irq", irq, 32'h0);
    rd(ra(0, 'h0C), v);      chk("R9", "masked status zero", v, 32'h0);
    wr(ra(0, 'h14), ~dst);
    chk("R7", "irq waits one cycle after unmask", irq, 32'h0);
    idle1();
    chk("R7", "irq after unmask", irq, dst);
    wr(ra(0, 'h18), 32'h0);
    rd(ra(0, 'h10), v);      chk("R11", "iclr returns idle", v, 32'h11);
    rd(ra(0, 'h00), v);      chk("R11", "owner kept", v, own);
    wr(ra(0, 'h08), dst);
    idle1();
    chk("R7", "irq cleared", irq, 32'h0);

    // R2 relock, R3 ignored data write
    wr(12'hA00, 32'h0);      rd(12'hA00, v);
    chk("R2", "lock closed by other value", v, 32'h1);
    wr(ra(3, 'h20), 32'hDEAD_BEEF);
    rd(ra(3, 'h20), v);
    chk("R3", "data write while locked", v, 32'hA500_0000 ^ (3 * 32'h0101_0101));
    wr(ra(3, 'h14), 32'h0);  rd(ra(3, 'h14), v);
    chk("R3", "mask kept while locked", v, ~(32'h1 << ((3 * 7 + 3) % 32)));

    done = 1;
  end

  initial begin
    fork
      begin
        repeat (200000) @(posedge clk);
        if (!done) begin
          checks++; errors++;
          $display("FAIL watchdog: actual timeout expected completion");
        end
      end
      wait (done);
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule